// File: doc/BRIEF.md
# Processor halt and shutdown controller

This block follows the sleep state of a processor core. A halt-instruction strobe takes a running core through two bus-cycle announcements, first a halt cycle and then a stop-grant cycle. The core then rests either in a plain halted state or, when a configuration bit asks for it, in a low-power suspend state. System-management, non-maskable and maskable interrupts wake it again. A one-cycle resume strobe reports, as a one-hot cause, which of them won. Next to it stands the restart address, which is the address just past the halt instruction.

A triple-fault strobe sends the core into shutdown. A synchronous reset always leaves shutdown. A non-maskable interrupt leaves it only when the interrupt-table limit and the stack pointer leave room for the interrupt frame; every other event is ignored there. Fault detection, the pipeline and the bus unit lie outside the block and are seen only as strobes and levels.

Top module: `core_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to running (`run_state_o` = 0) with `halt_cyc_o`, `stop_grant_o`, `suspend_o`, `resume_o`, `wake_cause_o` and `resume_pc_o` all zero.
- R2: A `halt_i` sampled while running (and no triple fault) raises `halt_cyc_o` for exactly the next cycle, then `stop_grant_o` for exactly the cycle after that; `run_state_o` reads 1 (halted) from the first of these cycles.
- R3: At the edge that ends the stop-grant cycle, `susp_en_i` = 1 moves the core to suspend (`run_state_o` = 2, `suspend_o` = 1), and `susp_en_i` = 0 keeps it halted (`run_state_o` = 1, `suspend_o` = 0).
- R4: In the halted or suspended state, a wake event returns the core to running at the next edge, with `resume_o` high for one cycle. During that cycle `wake_cause_o` is one-hot: bit 2 is SMI, bit 1 is NMI, bit 0 is INTR. When several events arrive together, SMI beats NMI and NMI beats INTR. `wake_cause_o` is zero whenever `resume_o` is low. Wake inputs seen during the halt or stop-grant cycle are not acted on until the core has reached the resting state.
- R5: `intr_i` wakes the core only while `if_flag_i` = 1; with the flag at 0 the core stays halted and no resume is reported.
- R6: `resume_pc_o` holds the last accepted halt's `halt_pc_i` plus `HALT_LEN` (the address of the next instruction), and keeps it across the wake.
- R7: `triple_fault_i` moves the core to shutdown (`run_state_o` = 3) at the next edge from any state, overriding a halt strobe or wake event in the same cycle.
- R8: In shutdown, SMI and INTR are ignored. NMI leaves shutdown, reporting `resume_o` with cause NMI, only when `idt_limit_i` >= 16'h000F and `sp_i` > 16'h0005; otherwise the core stays in shutdown.
- R9: Reset overrides every other event, in every state; it leaves suspend or shutdown without a resume strobe.
- R10: `halt_i` is ignored in every state except running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt-instruction strobe |
| halt_pc_i | input | ADDR_W | Address of the halt instruction, valid with `halt_i` |
| triple_fault_i | input | 1 | Triple-fault strobe |
| smi_i | input | 1 | System-management interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| intr_i | input | 1 | Maskable interrupt request |
| if_flag_i | input | 1 | Interrupt-enable flag |
| susp_en_i | input | 1 | Enter low-power suspend after halting |
| idt_limit_i | input | LIM_W | Current interrupt-table limit |
| sp_i | input | LIM_W | Current stack pointer |
| halt_cyc_o | output | 1 | One-cycle halt bus-cycle strobe |
| stop_grant_o | output | 1 | One-cycle stop-grant bus-cycle strobe |
| suspend_o | output | 1 | Core is in low-power suspend |
| resume_o | output | 1 | One-cycle resume strobe |
| wake_cause_o | output | 3 | One-hot wake cause {SMI, NMI, INTR} |
| resume_pc_o | output | ADDR_W | Restart address after a halt |
| run_state_o | output | 2 | 0 running, 1 halted, 2 suspended, 3 shutdown |

## Verification
Every result is registered once, so it is due at the edge that follows the stimulus. The halt strobe shows one cycle after `halt_i`, stop-grant one cycle after that, and the resting state one cycle later again. A wake, a fault or a shutdown exit is seen at the first edge after it is presented. The bench drives each stimulus on a falling edge and compares all outputs on the next falling edge, after exactly one rising edge. For the three-step halt entry it therefore uses one table row per cycle, never one row for the whole sequence.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

   typedef enum logic [2:0] {
      S_RUN,
      S_HBUS,
      S_SGNT,
      S_HALT,
      S_SUSP,
      S_SHUT
   } sleep_st_e;

   localparam logic [1:0] PH_RUN  = 2'd0;
   localparam logic [1:0] PH_HALT = 2'd1;
   localparam logic [1:0] PH_SUSP = 2'd2;
   localparam logic [1:0] PH_SHUT = 2'd3;

   localparam int N_WAKE  = 3;
   localparam int BIT_SMI = 2;
   localparam int BIT_NMI = 1;
   localparam int BIT_INT = 0;

endpackage

// File: rtl/wake_arbiter.sv
module wake_arbiter #(
   parameter int N = 3
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   if (N < 1) begin : g_bad_n
      $error("wake_arbiter: N must be at least 1");
   end

   logic [N-1:0] above;

   assign above[N-1] = 1'b0;
   assign gnt[N-1]   = req[N-1];

   for (genvar i = N - 2; i >= 0; i--) begin : g_pri
      assign above[i] = above[i+1] | req[i+1];
      assign gnt[i]   = req[i] & ~above[i];
   end

   // R4: at most one wake source is granted
   always_comb begin
      a_r4_grant_onehot0 : assert ($onehot0(gnt) || $isunknown(req));
   end

endmodule

// File: rtl/nmi_gate.sv
module nmi_gate #(
   parameter int              LIM_W   = 16,
   parameter logic [LIM_W-1:0] IDT_MIN = 'h000F,
   parameter logic [LIM_W-1:0] SP_MIN  = 'h0005
) (
   input  logic [LIM_W-1:0] idt_limit,
   input  logic [LIM_W-1:0] sp,
   output logic             frame_ok
);

   if (LIM_W < 4) begin : g_bad_w
      $error("nmi_gate: LIM_W too small for the frame bounds");
   end

   assign frame_ok = (idt_limit >= IDT_MIN) && (sp > SP_MIN);

endmodule

// File: rtl/core_sleep_ctrl.sv
module core_sleep_ctrl
   import sleep_pkg::*;
#(
   parameter int              ADDR_W       = 32,
   parameter int              HALT_LEN     = 1,
   parameter int              LIM_W        = 16,
   parameter logic [LIM_W-1:0] IDT_MIN      = 'h000F,
   parameter logic [LIM_W-1:0] SP_MIN       = 'h0005,
   parameter bit              SUSPEND_CAPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              halt_i,
   input  logic [ADDR_W-1:0] halt_pc_i,
   input  logic              triple_fault_i,
   input  logic              smi_i,
   input  logic              nmi_i,
   input  logic              intr_i,
   input  logic              if_flag_i,
   input  logic              susp_en_i,
   input  logic [LIM_W-1:0]  idt_limit_i,
   input  logic [LIM_W-1:0]  sp_i,
   output logic              halt_cyc_o,
   output logic              stop_grant_o,
   output logic              suspend_o,
   output logic              resume_o,
   output logic [2:0]        wake_cause_o,
   output logic [ADDR_W-1:0] resume_pc_o,
   output logic [1:0]        run_state_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(HALT_LEN);

   if (HALT_LEN < 1) begin : g_bad_len
      $error("core_sleep_ctrl: HALT_LEN must be positive");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("core_sleep_ctrl: ADDR_W must be at least 8");
   end

   sleep_st_e            st_q, st_n;
   logic                 rsm_q, rsm_n;
   logic [N_WAKE-1:0]    cause_q, cause_n;
   logic [ADDR_W-1:0]    pc_q;
   logic [N_WAKE-1:0]    wake_req, wake_gnt;
   logic                 frame_ok;
   logic                 go_susp;

   assign wake_req[BIT_SMI] = smi_i;
   assign wake_req[BIT_NMI] = nmi_i;
   assign wake_req[BIT_INT] = intr_i & if_flag_i;

   wake_arbiter #(.N(N_WAKE)) u_arb (
      .req (wake_req),
      .gnt (wake_gnt)
   );

   nmi_gate #(.LIM_W(LIM_W), .IDT_MIN(IDT_MIN), .SP_MIN(SP_MIN)) u_gate (
      .idt_limit (idt_limit_i),
      .sp        (sp_i),
      .frame_ok  (frame_ok)
   );

   if (SUSPEND_CAPS) begin : g_susp
      assign go_susp = susp_en_i;
   end else begin : g_nosusp
      logic unused_susp;
      assign unused_susp = susp_en_i;
      assign go_susp     = 1'b0;
   end

   always_comb begin
      st_n    = st_q;
      rsm_n   = 1'b0;
      cause_n = '0;
      if (triple_fault_i) begin
         st_n = S_SHUT;
      end else begin
         unique case (st_q)
            S_RUN:  if (halt_i) st_n = S_HBUS;
            S_HBUS: st_n = S_SGNT;
            S_SGNT: st_n = go_susp ? S_SUSP : S_HALT;
            S_HALT, S_SUSP: begin
               if (|wake_gnt) begin
                  st_n    = S_RUN;
                  rsm_n   = 1'b1;
                  cause_n = wake_gnt;
               end
            end
            S_SHUT: begin
               if (nmi_i && frame_ok) begin
                  st_n             = S_RUN;
                  rsm_n            = 1'b1;
                  cause_n[BIT_NMI] = 1'b1;
               end
            end
            default: st_n = S_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= S_RUN;
         rsm_q   <= 1'b0;
         cause_q <= '0;
         pc_q    <= '0;
      end else begin
         st_q    <= st_n;
         rsm_q   <= rsm_n;
         cause_q <= cause_n;
         if (st_q == S_RUN && halt_i && !triple_fault_i) begin
            pc_q <= halt_pc_i + STEP;
         end
      end
   end

   always_comb begin
      unique case (st_q)
         S_RUN:                  run_state_o = PH_RUN;
         S_HBUS, S_SGNT, S_HALT: run_state_o = PH_HALT;
         S_SUSP:                 run_state_o = PH_SUSP;
         default:                run_state_o = PH_SHUT;
      endcase
   end

   assign halt_cyc_o   = (st_q == S_HBUS);
   assign stop_grant_o = (st_q == S_SGNT);
   assign suspend_o    = (st_q == S_SUSP);
   assign resume_o     = rsm_q;
   assign wake_cause_o = cause_q;
   assign resume_pc_o  = pc_q;

   // R2: a halt accepted while running raises the halt strobe next cycle
   a_r2_halt_entry : assert property (@(posedge clk) disable iff (rst)
      (run_state_o == PH_RUN && halt_i && !triple_fault_i) |=> halt_cyc_o);

   // R2: halt strobe is single and is followed by stop-grant
   a_r2_halt_then_grant : assert property (@(posedge clk) disable iff (rst)
      (halt_cyc_o && !triple_fault_i) |=> (stop_grant_o && !halt_cyc_o));

   // R3: suspend begins only right after a stop-grant cycle
   a_r3_susp_after_grant : assert property (@(posedge clk) disable iff (rst)
      $rose(suspend_o) |-> $past(stop_grant_o));

   // R4: a resume carries exactly one cause
   a_r4_cause_onehot : assert property (@(posedge clk) disable iff (rst)
      resume_o |-> ($countones(wake_cause_o) == 1));

   // R4: no cause without a resume
   a_r4_cause_quiet : assert property (@(posedge clk) disable iff (rst)
      !resume_o |-> (wake_cause_o == '0));

   // R7: a triple fault lands in shutdown
   a_r7_fault_shutdown : assert property (@(posedge clk) disable iff (rst)
      triple_fault_i |=> (run_state_o == PH_SHUT));

   // R8: without NMI nothing leaves shutdown
   a_r8_shut_hold : assert property (@(posedge clk) disable iff (rst)
      (run_state_o == PH_SHUT && !nmi_i) |=> (run_state_o == PH_SHUT && !resume_o));

endmodule

// File: tb/core_sleep_ctrl_tb.sv
module core_sleep_ctrl_tb;

   localparam logic H = 1'b1;
   localparam logic L = 1'b0;

   typedef struct packed {
      logic       halt, tf, smi, nmi, intr, ifl, sen, lok, sok;
      logic [1:0] st;
      logic       hc, sg, su, rs;
      logic [2:0] cz;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 31;
   // fields: halt tf smi nmi intr ifl sen lok sok | st hc sg su rs cause | req
   localparam vec_t VECS [NV] = '{
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2 halt strobe
      '{L,L,L,L,L,L,L,H,H, 2'd1,L,H,L,L,3'b000, 4'd2},  // R2 stop-grant
      '{L,L,L,L,L,L,L,H,H, 2'd1,L,L,L,L,3'b000, 4'd3},  // R3 plain halt
      '{L,L,L,L,H,L,L,H,H, 2'd1,L,L,L,L,3'b000, 4'd5},  // R5 masked INTR
      '{L,L,L,L,H,H,L,H,H, 2'd0,L,L,L,H,3'b001, 4'd4},  // R4 INTR wake
      '{L,L,L,L,L,L,L,H,H, 2'd0,L,L,L,L,3'b000, 4'd4},  // R4 strobe ends
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,L,H,H, 2'd1,L,H,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,H,H,H, 2'd2,L,L,H,L,3'b000, 4'd3},  // R3 suspend
      '{L,L,H,H,H,H,L,H,H, 2'd0,L,L,L,H,3'b100, 4'd4},  // R4 SMI first
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,L,H,H, 2'd1,L,H,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,H,H,H, 2'd2,L,L,H,L,3'b000, 4'd3},  // R3
      '{L,L,L,H,H,H,L,H,H, 2'd0,L,L,L,H,3'b010, 4'd4},  // R4 NMI over INTR
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,L,H,H, 2'd1,L,H,L,L,3'b000, 4'd2},  // R2
      '{L,L,L,L,L,L,H,H,H, 2'd2,L,L,H,L,3'b000, 4'd3},  // R3
      '{L,H,H,L,L,L,L,H,H, 2'd3,L,L,L,L,3'b000, 4'd7},  // R7 fault beats SMI
      '{L,L,H,L,H,H,L,H,H, 2'd3,L,L,L,L,3'b000, 4'd8},  // R8 SMI/INTR ignored
      '{L,L,L,H,L,L,L,L,H, 2'd3,L,L,L,L,3'b000, 4'd8},  // R8 limit 000E
      '{L,L,L,H,L,L,L,H,L, 2'd3,L,L,L,L,3'b000, 4'd8},  // R8 sp 0005
      '{L,L,L,H,L,L,L,H,H, 2'd0,L,L,L,H,3'b010, 4'd8},  // R8 NMI exit
      '{H,H,L,L,L,L,L,H,H, 2'd3,L,L,L,L,3'b000, 4'd7},  // R7 fault beats halt
      '{L,L,L,H,L,L,L,H,H, 2'd0,L,L,L,H,3'b010, 4'd8},  // R8
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2
      '{L,H,L,L,L,L,L,H,H, 2'd3,L,L,L,L,3'b000, 4'd7},  // R7 from halt cycle
      '{L,L,L,H,L,L,L,H,H, 2'd0,L,L,L,H,3'b010, 4'd8},  // R8
      '{H,L,L,L,L,L,L,H,H, 2'd1,H,L,L,L,3'b000, 4'd2},  // R2
      '{H,L,L,L,L,L,L,H,H, 2'd1,L,H,L,L,3'b000, 4'd10}, // R10 halt ignored
      '{H,L,L,L,L,L,L,H,H, 2'd1,L,L,L,L,3'b000, 4'd10}, // R10 halt ignored
      '{L,L,H,L,L,L,L,H,H, 2'd0,L,L,L,H,3'b100, 4'd4}   // R4 SMI wake
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        halt_i = 1'b0, triple_fault_i = 1'b0;
   logic        smi_i = 1'b0, nmi_i = 1'b0, intr_i = 1'b0;
   logic        if_flag_i = 1'b0, susp_en_i = 1'b0;
   logic [31:0] halt_pc_i = '0;
   logic [15:0] idt_limit_i = 16'h000F, sp_i = 16'h0006;
   logic        halt_cyc_o, stop_grant_o, suspend_o, resume_o;
   logic [2:0]  wake_cause_o;
   logic [31:0] resume_pc_o;
   logic [1:0]  run_state_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   core_sleep_ctrl u_dut (
      .clk (clk), .rst (rst), .halt_i (halt_i), .halt_pc_i (halt_pc_i),
      .triple_fault_i (triple_fault_i), .smi_i (smi_i), .nmi_i (nmi_i),
      .intr_i (intr_i), .if_flag_i (if_flag_i), .susp_en_i (susp_en_i),
      .idt_limit_i (idt_limit_i), .sp_i (sp_i),
      .halt_cyc_o (halt_cyc_o), .stop_grant_o (stop_grant_o),
      .suspend_o (suspend_o), .resume_o (resume_o),
      .wake_cause_o (wake_cause_o), .resume_pc_o (resume_pc_o),
      .run_state_o (run_state_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiet();
      halt_i = 0; triple_fault_i = 0; smi_i = 0; nmi_i = 0; intr_i = 0;
      if_flag_i = 0; susp_en_i = 0; idt_limit_i = 16'h000F; sp_i = 16'h0006;
   endtask

   task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   function automatic logic [8:0] outs();
      return {run_state_o, halt_cyc_o, stop_grant_o, suspend_o, resume_o, wake_cause_o};
   endfunction

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      step();
      check("R1 reset outputs", outs(), 9'b0);
      check("R1 reset pc", {1'b0, resume_pc_o[7:0]}, 9'b0);
      rst = 0;

      for (int i = 0; i < NV; i++) begin
         halt_i = VECS[i].halt; triple_fault_i = VECS[i].tf;
         smi_i = VECS[i].smi; nmi_i = VECS[i].nmi; intr_i = VECS[i].intr;
         if_flag_i = VECS[i].ifl; susp_en_i = VECS[i].sen;
         idt_limit_i = VECS[i].lok ? 16'h000F : 16'h000E;
         sp_i = VECS[i].sok ? 16'h0006 : 16'h0005;
         step();
         check($sformatf("R%0d row %0d", VECS[i].req, i), outs(),
               {VECS[i].st, VECS[i].hc, VECS[i].sg, VECS[i].su, VECS[i].rs, VECS[i].cz});
      end
      quiet();
      step();

      // R6: restart address is the halt address plus the instruction length
      halt_pc_i = 32'h0000_2340; halt_i = 1;
      step();
      halt_i = 0; halt_pc_i = 32'h0000_9990;
      step();
      step();
      smi_i = 1;
      step();
      smi_i = 0;
      check("R6 resume with smi", outs(), {2'd0, 4'b0001, 3'b100});
      n_chk++;
      if (resume_pc_o !== 32'h0000_2341) begin
         n_fail++;
         $display("FAIL R6: got %h expected %h", resume_pc_o, 32'h0000_2341);
      end

      // R4: wake during the halt/stop-grant cycles waits for the rest state
      halt_i = 1;
      step();
      halt_i = 0; smi_i = 1;
      step();
      check("R4 no wake in stop-grant", outs(), {2'd1, 4'b0100, 3'b000});
      step();
      check("R4 no wake before rest", outs(), {2'd1, 4'b0000, 3'b000});
      step();
      check("R4 wake from rest", outs(), {2'd0, 4'b0001, 3'b100});
      smi_i = 0;

      // R9: reset leaves suspend and outranks a pending SMI
      halt_i = 1;
      step();
      halt_i = 0; susp_en_i = 1;
      step();
      step();
      check("R9 suspended before reset", outs(), {2'd2, 4'b0010, 3'b000});
      rst = 1; smi_i = 1;
      step();
      check("R9 reset from suspend", outs(), 9'b0);
      rst = 0; smi_i = 0; susp_en_i = 0;

      // R9: reset leaves shutdown without a resume
      triple_fault_i = 1;
      step();
      triple_fault_i = 0;
      check("R7 fault from running", outs(), {2'd3, 4'b0000, 3'b000});
      rst = 1; nmi_i = 1;
      step();
      check("R9 reset from shutdown", outs(), 9'b0);
      rst = 0; nmi_i = 0;
      step();
      check("R1 idle after reset", outs(), 9'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule